// File: doc/BRIEF.md
# Retransmission Copy Tracker

This block sits beside an injection port of a switch and keeps one entry for every packet still in flight whose backup copy has been parked in spare buffering elsewhere in the switch. An entry opens when a packet is admitted. Admission happens only when the packet's normal route and a route to stash storage are both free.

Two independent reports close the entry:
- a location report, which says which port and which slot hold the copy;
- the end-to-end response from the destination, which is either positive or negative.

Once an entry holds both reports, the block sends one command to the stored location. A positive response produces a delete, which frees the slot. A negative response produces a retransmit.

The response can arrive before the location report. In that case the entry stays open with the response pending, and the command goes out as soon as the location becomes known. Bookkeeping traffic carries only the tracking index, a port number and a slot index.

Top module: `rct_tracker`

## Requirements
- R1: `issue_accept` is high, in the same cycle, exactly when `issue_req`, `normal_ready` and `stash_ready` are all high and the entry at `issue_idx` is free. In every other case the packet stalls and no entry is opened.
- R2: The port and slot of a location report are stored in the entry named by `loc_idx`. They appear on `cmd_port` and `cmd_slot` when that entry's command is issued.
- R3: A positive response (`ack_pos` = 1) to an entry whose location is known yields `cmd_valid` with `cmd_op` = 0 (delete) in the cycle after the response is captured.
- R4: A negative response (`ack_pos` = 0) to an entry whose location is known yields `cmd_op` = 1 (retransmit) in the cycle after the response is captured.
- R5: A response that arrives before the location report produces no command. The entry stays open, and the pending command, with the stored polarity, is issued in the cycle after the location report is captured.
- R6: A location report and a response for the same index in the same cycle are both applied. The command follows in the next cycle.
- R7: At most one command is issued per cycle. When several entries are complete, the lowest tracking index is issued first, and the others follow in later cycles.
- R8: An entry is freed in the cycle its command is issued. Location reports and responses that name a free entry are ignored and produce no command.
- R9: After reset all entries are free and `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_req | input | 1 | A packet asks to be admitted |
| issue_idx | input | TRK_W | Tracking index of that packet |
| normal_ready | input | 1 | Normal route is available |
| stash_ready | input | 1 | A stash route is available |
| issue_accept | output | 1 | Packet admitted, entry opened |
| loc_valid | input | 1 | Location report present |
| loc_idx | input | TRK_W | Tracking index of the report |
| loc_port | input | PORT_W | Port holding the copy |
| loc_slot | input | SLOT_W | Slot holding the copy |
| ack_valid | input | 1 | End-to-end response present |
| ack_idx | input | TRK_W | Tracking index of the response |
| ack_pos | input | 1 | 1 = positive, 0 = negative |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 1 | 0 = delete, 1 = retransmit |
| cmd_port | output | PORT_W | Target port of the command |
| cmd_slot | output | SLOT_W | Target slot of the command |

## Verification
`issue_accept` is combinational, so the bench checks it 1 ns after driving the inputs, inside the same cycle.

A command is due in the cycle after the clock edge that captures the later of the two reports for an entry. The bench checks every command output at the falling edge that follows that capture. At that same edge it drives the next stimulus, so each check sees exactly one cycle of state change.

The expected command is computed from a bench model that applies each edge's updates in the same order as R1, R6, R7 and R8.

// File: rtl/rct_pkg.sv
package rct_pkg;
    typedef enum logic {
        CMD_DELETE = 1'b0,
        CMD_RESEND = 1'b1
    } cmd_op_e;
endpackage

// File: rtl/rct_entry.sv
module rct_entry
    import rct_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic              loc_hit,
    input  logic [PORT_W-1:0] loc_port,
    input  logic [SLOT_W-1:0] loc_slot,
    input  logic              ack_hit,
    input  logic              ack_pos,
    input  logic              release_i,
    output logic              busy,
    output logic              ready,
    output cmd_op_e           op,
    output logic [PORT_W-1:0] port_o,
    output logic [SLOT_W-1:0] slot_o
);
    typedef struct packed {
        logic              valid;
        logic              loc_known;
        logic              ack_seen;
        logic              ack_good;
        logic [PORT_W-1:0] port;
        logic [SLOT_W-1:0] slot;
    } ent_t;

    ent_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (release_i) begin
            st_d = '0;
        end else if (alloc) begin
            st_d       = '0;
            st_d.valid = 1'b1;
        end else if (st_q.valid) begin
            if (loc_hit) begin
                st_d.loc_known = 1'b1;
                st_d.port      = loc_port;
                st_d.slot      = loc_slot;
            end
            if (ack_hit) begin
                st_d.ack_seen = 1'b1;
                st_d.ack_good = ack_pos;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.valid;
    assign ready  = st_q.valid && st_q.loc_known && st_q.ack_seen;
    assign op     = st_q.ack_good ? CMD_DELETE : CMD_RESEND;
    assign port_o = st_q.port;
    assign slot_o = st_q.slot;

    AST_WAIT_FOR_LOC: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !st_q.loc_known && !loc_hit && !release_i) |=> !ready); // R5
    AST_RELEASE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> ready); // R8
    AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> !busy); // R8
endmodule

// File: rtl/rct_pick.sv
module rct_pick #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N:0] below;

    assign below[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_pri
        assign grant[i]   = req[i] && !below[i];
        assign below[i+1] = below[i] || req[i];
    end

    assign any = below[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/rct_tracker.sv
module rct_tracker
    import rct_pkg::*;
#(
    parameter int NUM_TRK = 16,
    parameter int PORT_W  = 4,
    parameter int SLOT_W  = 8,
    localparam int TRK_W  = (NUM_TRK > 1) ? $clog2(NUM_TRK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_req,
    input  logic [TRK_W-1:0]  issue_idx,
    input  logic              normal_ready,
    input  logic              stash_ready,
    output logic              issue_accept,
    input  logic              loc_valid,
    input  logic [TRK_W-1:0]  loc_idx,
    input  logic [PORT_W-1:0] loc_port,
    input  logic [SLOT_W-1:0] loc_slot,
    input  logic              ack_valid,
    input  logic [TRK_W-1:0]  ack_idx,
    input  logic              ack_pos,
    output logic              cmd_valid,
    output logic              cmd_op,
    output logic [PORT_W-1:0] cmd_port,
    output logic [SLOT_W-1:0] cmd_slot
);
    logic [NUM_TRK-1:0] busy_vec;
    logic [NUM_TRK-1:0] ready_vec;
    logic [NUM_TRK-1:0] grant_vec;
    logic [NUM_TRK-1:0] alloc_vec;
    logic [TRK_W-1:0]   pick_idx;
    logic               pick_any;
    logic               slot_free;
    cmd_op_e            op_arr   [NUM_TRK];
    logic [PORT_W-1:0]  port_arr [NUM_TRK];
    logic [SLOT_W-1:0]  slot_arr [NUM_TRK];

    assign slot_free    = (int'(issue_idx) < NUM_TRK) && !busy_vec[issue_idx];
    assign issue_accept = issue_req && normal_ready && stash_ready && slot_free;

    for (genvar i = 0; i < NUM_TRK; i++) begin : g_ent
        assign alloc_vec[i] = issue_accept && (issue_idx == TRK_W'(i));

        rct_entry #(
            .PORT_W (PORT_W),
            .SLOT_W (SLOT_W)
        ) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc_vec[i]),
            .loc_hit   (loc_valid && (loc_idx == TRK_W'(i))),
            .loc_port  (loc_port),
            .loc_slot  (loc_slot),
            .ack_hit   (ack_valid && (ack_idx == TRK_W'(i))),
            .ack_pos   (ack_pos),
            .release_i (grant_vec[i]),
            .busy      (busy_vec[i]),
            .ready     (ready_vec[i]),
            .op        (op_arr[i]),
            .port_o    (port_arr[i]),
            .slot_o    (slot_arr[i])
        );
    end

    rct_pick #(.N(NUM_TRK)) u_pick (
        .req   (ready_vec),
        .grant (grant_vec),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    assign cmd_valid = pick_any;
    assign cmd_op    = op_arr[pick_idx];
    assign cmd_port  = port_arr[pick_idx];
    assign cmd_slot  = slot_arr[pick_idx];

    AST_ACCEPT_PATHS: assert property (@(posedge clk) disable iff (!rst_n)
        issue_accept |-> (normal_ready && stash_ready)); // R1
    AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        issue_accept |=> busy_vec[$past(issue_idx)]); // R1
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec)); // R7
    AST_CMD_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !busy_vec[$past(pick_idx)]); // R8
endmodule

// File: tb/sim_rct_tracker.sv
module sim_rct_tracker;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N  = 16;
    localparam int PW = 4;
    localparam int SW = 8;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_req = 0, normal_ready = 0, stash_ready = 0;
    logic [IW-1:0] issue_idx = '0;
    logic          issue_accept;
    logic          loc_valid = 0;
    logic [IW-1:0] loc_idx = '0;
    logic [PW-1:0] loc_port = '0;
    logic [SW-1:0] loc_slot = '0;
    logic          ack_valid = 0, ack_pos = 0;
    logic [IW-1:0] ack_idx = '0;
    logic          cmd_valid, cmd_op;
    logic [PW-1:0] cmd_port;
    logic [SW-1:0] cmd_slot;

    always #10 clk = ~clk;

    rct_tracker #(.NUM_TRK(N), .PORT_W(PW), .SLOT_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .issue_req(issue_req), .issue_idx(issue_idx),
        .normal_ready(normal_ready), .stash_ready(stash_ready),
        .issue_accept(issue_accept),
        .loc_valid(loc_valid), .loc_idx(loc_idx), .loc_port(loc_port), .loc_slot(loc_slot),
        .ack_valid(ack_valid), .ack_idx(ack_idx), .ack_pos(ack_pos),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_port(cmd_port), .cmd_slot(cmd_slot)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit m_v [N];
    bit m_l [N];
    bit m_a [N];
    bit m_p [N];
    int m_port [N];
    int m_slot [N];

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lowest_ready();
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_l[i] && m_a[i]) return i;
        return -1;
    endfunction

    task automatic cyc(string ctag, bit req, int idx, bit nr, bit sr,
                       bit lv, int li, int lp, int ls, bit av, int ai, bit ap);
        int e;
        bit acc;
        bit pre_v [N];
        @(negedge clk);
        e = lowest_ready();
        if (e < 0) begin
            check({ctag, " no cmd"}, int'(cmd_valid), 0);
        end else begin
            check({ctag, " cmd_valid"}, int'(cmd_valid), 1);
            check({ctag, " op"}, int'(cmd_op), m_p[e] ? 0 : 1);
            check({ctag, " R2 port"}, int'(cmd_port), m_port[e]);
            check({ctag, " R2 slot"}, int'(cmd_slot), m_slot[e]);
        end
        issue_req = req; issue_idx = IW'(idx); normal_ready = nr; stash_ready = sr;
        loc_valid = lv; loc_idx = IW'(li); loc_port = PW'(lp); loc_slot = SW'(ls);
        ack_valid = av; ack_idx = IW'(ai); ack_pos = ap;
        #1;
        acc = req && nr && sr && !m_v[idx];
        check("R1 accept", int'(issue_accept), int'(acc));
        for (int i = 0; i < N; i++) pre_v[i] = m_v[i];
        if (e >= 0) begin
            m_v[e] = 0; m_l[e] = 0; m_a[e] = 0; m_p[e] = 0;
        end
        if (acc) begin
            m_v[idx] = 1; m_l[idx] = 0; m_a[idx] = 0; m_p[idx] = 0;
            m_port[idx] = 0; m_slot[idx] = 0;
        end
        if (lv && pre_v[li] && li != e) begin
            m_l[li] = 1; m_port[li] = lp; m_slot[li] = ls;
        end
        if (av && pre_v[ai] && ai != e) begin
            m_a[ai] = 1; m_p[ai] = ap;
        end
    endtask

    task automatic idle(string ctag);
        cyc(ctag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_l[i] = 0; m_a[i] = 0; m_p[i] = 0; m_port[i] = 0; m_slot[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R9 reset");
        cyc("R9", 1, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0);        // R1 stash path busy
        cyc("R9", 1, 3, 0, 1, 0, 0, 0, 0, 0, 0, 0);        // R1 normal path busy
        cyc("R9", 1, 3, 1, 1, 0, 0, 0, 0, 0, 0, 0);        // R1 admitted
        cyc("R5", 1, 3, 1, 1, 0, 0, 0, 0, 1, 3, 1);        // R1 busy reject, ack first
        idle("R5 ack before loc");
        cyc("R5 ack before loc", 0, 0, 0, 0, 1, 3, 5, 42, 0, 0, 0);
        idle("R5 R3 delete after late loc");
        cyc("R8 released", 0, 0, 0, 0, 0, 0, 0, 0, 1, 3, 1);
        cyc("R8 stale ack ignored", 0, 0, 0, 0, 1, 3, 6, 7, 0, 0, 0);
        cyc("R8 stale loc ignored", 1, 7, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R6", 0, 0, 0, 0, 1, 7, 9, 85, 1, 7, 0);
        idle("R6 R4 retransmit same-cycle");
        cyc("R8", 1, 2, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R7", 1, 9, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R7", 0, 0, 0, 0, 1, 2, 1, 17, 1, 9, 1);
        cyc("R7 partial", 0, 0, 0, 0, 1, 9, 12, 200, 1, 2, 0);
        idle("R7 lowest first");
        idle("R7 next entry");
        idle("R7 drained");
        for (int k = 0; k < 4000; k++) begin
            cyc("R3 R4 R7 random",
                ($urandom % 2) == 0, int'($urandom % N), ($urandom % 4) != 0, ($urandom % 4) != 0,
                ($urandom % 5) < 2, int'($urandom % N), int'($urandom % 16), int'($urandom % 256),
                ($urandom % 5) < 2, int'($urandom % N), ($urandom % 3) != 0);
        end
        for (int k = 0; k < N + 2; k++) idle("R7 drain");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule